// File: doc/BRIEF.md
# Twin-Rate Clock Divider

This block takes a fast reference clock, nominally 1 MHz, and produces two slow timing signals from it, both at 1 Hz with the default settings. The first is a strobe that is high for one reference cycle per output period. It is read straight from an equality comparator that watches a free-running counter. When the comparator matches, the counter is cleared synchronously on the next enabled edge. A clear value of N therefore gives a period of N+1 reference cycles. The second output is a square wave with a 50% duty cycle. A flip-flop produces it by toggling each time a second counter reaches its own, half-period terminal value.

Both terminal values are parameters. The defaults, 999,999 for the strobe and 499,999 for the half period, give an exact 1 Hz strobe and an exact 1 Hz square wave. A count enable freezes all state while it is low. A synchronous reset returns both counters to zero and drives the square wave low. Neither output is meant to clock other logic. Both are intended as enables or as level signals sampled in the reference domain.

The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and status signals.

Top module: `rate_divider`

## Requirements
- R1: While `srst_i` is high at a rising edge, `count_o` becomes 0 and `square_o` becomes 0 after that edge. The hidden half-period counter also returns to 0.
- R2: After a rising edge with `run_i` high and `count_o` below `PULSE_TERM`, `count_o` has increased by exactly one.
- R3: After a rising edge with `run_i` high and `count_o` equal to `PULSE_TERM`, `count_o` is 0. With `run_i` held high, the count sequence therefore repeats every `PULSE_TERM`+1 cycles.
- R4: `strobe_o` is high exactly when `count_o` equals `PULSE_TERM` and `run_i` is high. With `run_i` held high, it is one cycle wide once per period.
- R5: `square_o` inverts on each enabled edge at which the half-period counter equals `HALF_TERM`. After reset, `square_o` is low for the first `HALF_TERM`+1 enabled cycles. From then on, each high level and each low level lasts `HALF_TERM`+1 enabled cycles.
- R6: At a rising edge with `run_i` low, `count_o`, the half-period counter and `square_o` keep their values. While `run_i` is low, `strobe_o` is low.
- R7: `srst_i` takes priority over `run_i`. A reset edge with `run_i` high still clears the block, and it does not toggle `square_o`.
- R8: `count_o` is `$clog2(PULSE_TERM+1)` bits wide and never exceeds `PULSE_TERM`. Both terminal values must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; all state changes on its rising edge |
| srst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Count enable; low freezes all state |
| strobe_o | output | 1 | One-cycle strobe when the main count sits at its terminal value |
| square_o | output | 1 | Square wave with 50% duty, toggled at each half-period match |
| count_o | output | $clog2(PULSE_TERM+1) | Current value of the main counter |

## Verification
The assertions assume the following about the inputs. `srst_i` is high at the first rising edge. Both terminal values are at least 1, so a match is never followed directly by another match. `run_i` and `srst_i` are stable around each rising edge. The bench meets these conditions in three ways. It holds reset across the first two edges. It uses small terms of 6 and 3. It changes every input on the falling edge. The stimulus covers a long stretch with the enable held high, an irregular enable pattern, and a reset applied while the enable is high.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;

  // Number of bits needed to hold every value from 0 to term inclusive.
  function automatic int unsigned term_bits(input int unsigned term);
    if (term < 1) return 1;
    return $clog2(term + 1);
  endfunction

endpackage

// File: rtl/match_counter.sv
module match_counter #(
  parameter int unsigned TERM = 9,
  parameter int unsigned W    = rate_div_pkg::term_bits(TERM)
) (
  input  logic         clk_i,
  input  logic         srst_i,
  input  logic         step_i,
  output logic [W-1:0] count_o,
  output logic         at_term_o
);

  localparam logic [W-1:0] TERM_V = W'(TERM);

  logic [W-1:0] cnt_q;

  // Equality compare; its match selects a synchronous clear on the next step.
  assign at_term_o = (cnt_q == TERM_V);
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (srst_i)         cnt_q <= '0;
    else if (step_i)    cnt_q <= at_term_o ? '0 : cnt_q + 1'b1;
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (srst_i)
    (step_i && !at_term_o) |=> (count_o == $past(count_o) + 1'b1));

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (srst_i)
    (step_i && at_term_o) |=> (count_o == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (srst_i)
    !step_i |=> $stable(count_o));

  a_r8_in_range: assert property (@(posedge clk_i) disable iff (srst_i)
    count_o <= TERM_V);

endmodule

// File: rtl/toggle_flop.sv
module toggle_flop (
  input  logic clk_i,
  input  logic srst_i,
  input  logic flip_i,
  output logic q_o
);

  logic q_q;

  assign q_o = q_q;

  always_ff @(posedge clk_i) begin
    if (srst_i)      q_q <= 1'b0;
    else if (flip_i) q_q <= ~q_q;
  end

  a_r5_flip: assert property (@(posedge clk_i) disable iff (srst_i)
    flip_i |=> (q_o != $past(q_o)));

  a_r6_keep: assert property (@(posedge clk_i) disable iff (srst_i)
    !flip_i |=> $stable(q_o));

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int unsigned PULSE_TERM = 999_999,
  parameter int unsigned HALF_TERM  = 499_999,
  parameter int unsigned CW         = rate_div_pkg::term_bits(PULSE_TERM)
) (
  input  logic          clk_i,
  input  logic          srst_i,
  input  logic          run_i,
  output logic          strobe_o,
  output logic          square_o,
  output logic [CW-1:0] count_o
);

  localparam int unsigned HW = rate_div_pkg::term_bits(HALF_TERM);

  logic          main_match;
  logic [HW-1:0] half_cnt;
  logic          half_match;
  logic          half_flip;

  // Unbalanced path: the strobe is the comparator output, qualified by the enable.
  match_counter #(.TERM(PULSE_TERM), .W(CW)) u_main (
    .clk_i     (clk_i),
    .srst_i    (srst_i),
    .step_i    (run_i),
    .count_o   (count_o),
    .at_term_o (main_match)
  );

  assign strobe_o = run_i & main_match;

  // Balanced path: a half-period counter drives a toggle flop.
  match_counter #(.TERM(HALF_TERM), .W(HW)) u_half (
    .clk_i     (clk_i),
    .srst_i    (srst_i),
    .step_i    (run_i),
    .count_o   (half_cnt),
    .at_term_o (half_match)
  );

  assign half_flip = run_i & half_match;

  toggle_flop u_wave (
    .clk_i  (clk_i),
    .srst_i (srst_i),
    .flip_i (half_flip),
    .q_o    (square_o)
  );

  // Checked without the reset disable: the reset edge itself is what is checked.
  a_r1_reset: assert property (@(posedge clk_i)
    srst_i |=> (count_o == '0 && !square_o && half_cnt == '0));

  a_r4_single: assert property (@(posedge clk_i) disable iff (srst_i)
    strobe_o |=> !strobe_o);

  a_r6_quiet: assert property (@(posedge clk_i) disable iff (srst_i)
    !run_i |-> !strobe_o);

  a_r7_no_toggle_in_reset: assert property (@(posedge clk_i)
    (srst_i && run_i) |=> !square_o);

  a_r8_half_range: assert property (@(posedge clk_i) disable iff (srst_i)
    half_cnt <= HW'(HALF_TERM));

endmodule

// File: tb/test_rate_divider.sv
`timescale 1ns/1ps
module test_rate_divider;

  localparam int unsigned PT = 6;
  localparam int unsigned HT = 3;
  localparam int unsigned CW = rate_div_pkg::term_bits(PT);

  logic          clk = 1'b0;
  logic          srst = 1'b1;
  logic          run = 1'b0;
  logic          strobe;
  logic          square;
  logic [CW-1:0] count;

  always #2.5 clk = ~clk;

  rate_divider #(.PULSE_TERM(PT), .HALF_TERM(HT)) i_rate_divider (
    .clk_i    (clk),
    .srst_i   (srst),
    .run_i    (run),
    .strobe_o (strobe),
    .square_o (square),
    .count_o  (count)
  );

  typedef struct {
    int unsigned cnt;
    bit          pls;
    bit          sq;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;

  // Reference model, built from the requirements
  int unsigned m_cnt  = 0;
  int unsigned m_half = 0;
  bit          m_sq   = 0;

  // Driver: applies one cycle of stimulus, pushes what must be seen this cycle,
  // then advances the model as the coming rising edge will.
  task automatic step(input bit e, input bit r, input string tag);
    exp_t it;
    @(negedge clk);
    run  = e;
    srst = r;
    #1;
    it.cnt = m_cnt;
    it.pls = e && (m_cnt == PT);  // R4, R6
    it.sq  = m_sq;
    exp_q.push_back(it);
    tag_q.push_back(tag);
    if (r) begin                  // R1, R7
      m_cnt = 0; m_half = 0; m_sq = 0;
    end else if (e) begin
      m_cnt = (m_cnt == PT) ? 0 : m_cnt + 1;        // R2, R3
      if (m_half == HT) begin m_half = 0; m_sq = !m_sq; end  // R5
      else m_half = m_half + 1;
    end                           // else hold: R6
  endtask

  // Monitor: pops and compares after the driver has pushed
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t  it;
        string tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        total++;
        if (count !== CW'(it.cnt) || strobe !== it.pls || square !== it.sq) begin
          bad++;
          $display("FAIL %s: count=%0d strobe=%b square=%b expected count=%0d strobe=%b square=%b",
                   tg, count, strobe, square, it.cnt, it.pls, it.sq);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // Reset state, then enable held low
    step(0, 0, "R1 reset state");
    step(0, 0, "R6 idle after reset");
    // Long run with the enable held high: increment, wrap, strobe, square
    for (int i = 0; i < 40; i++) step(1, 0, "R2 R3 R4 R5 R8 free run");
    // Irregular enable pattern
    for (int i = 0; i < 45; i++) step((i % 3) != 0, 0, "R6 gated run");
    for (int i = 0; i < 7; i++) step((i % 2) == 0, 0, "R6 alternating");
    // Reset while enabled, with the square wave possibly high
    for (int i = 0; i < 5; i++) step(1, 0, "R5 before reset");
    step(1, 1, "R7 reset with enable");
    for (int i = 0; i < 30; i++) step(1, 0, "R1 R7 restart");
    for (int i = 0; i < 3; i++) step(0, 0, "R6 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule